// File: doc/BRIEF.md
# Three-Phase Sinusoidal PWM Generator

This block generates three gate-drive pulse trains, one per phase of a three-phase converter, by digital sinusoidal modulation. A shared triangular carrier runs from an 8-bit counter that climbs from 0 to 255 and falls back again. One sine period is stored as 60 samples. A pointer into those samples moves forward once for every carrier period, and it wraps after the last sample.

Each phase reads the sample table at its own offset, which spaces the three phases 120 degrees apart. The sample is scaled by a runtime amplitude word, giving the modulation depth, and is then compared with the carrier. The result of each comparison is registered before it leaves the block. The carrier level is also brought out so that it can be observed.

The pointer moves only at the carrier valley. A reference therefore never changes in the middle of a rising or falling slope, and every pulse stays centred on a carrier period.

Top module: `spwm3_gen`

## Requirements
- R1: Synchronous active-high reset sets the carrier to 0, counting upward, sets the table pointer to 0 and drives all three PWM outputs low.
- R2: After reset the carrier steps by exactly one count each clock. It runs 0,1,…,255,254,…,1,0,1,…, turning at 255 and at 0 without holding either end value, so one carrier period is 510 clocks.
- R3: Table entry i (0 ≤ i < 60) has the deviation d(i) = round(120·sin(2πi/60)) about a centre of 128, with halves rounded away from zero.
- R4: The table pointer moves forward by one, modulo 60, only on the clock edge where the carrier is 0 while counting downward. At every other edge it holds its value, so it returns to 0 after 60 carrier periods.
- R5: Phase k (k = 0, 1, 2, driving pwm_o bit k) reads table entry (pointer + 20·k) mod 60.
- R6: The scaled reference of a phase is 128 + floor(d·amp_i / 256), clamped to 0..255, where d is that phase's table deviation and amp_i is read as an unsigned value.
- R7: At each clock edge pwm_o bit k takes the value (carrier ≤ reference of phase k), evaluated on the carrier, pointer and amp_i values present just before that edge. A change of amp_i is therefore visible on pwm_o one clock later.
- R8: With amp_i held at 0, every phase output is high for 257 of the 510 clocks in any carrier-period window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| amp_i | input | 8 | Modulation amplitude, unsigned (0 = no modulation, 255 = near full) |
| carrier_o | output | 8 | Current triangular carrier level |
| pwm_o | output | 3 | Registered PWM outputs; bit 0 phase A, bit 1 phase B, bit 2 phase C |

## Verification
The bench follows a cycle-accurate arithmetic model of the block for whole pointer cycles at several amplitudes. This catches a carrier that repeats 0 or 255 at a turn, which shows up as a 511- or 512-clock period, and a pointer that wraps at 59 or 61 or advances at the peak, which desynchronises every later pulse. Changing amp_i every few dozen clocks exposes a comparison that is registered twice or not at all, because the output edges would land one clock off. Zero amplitude checks the 257-of-510 duty, which a strict less-than comparison would turn into 255. The signed scaling is checked on the negative half-wave, where a logical shift in place of an arithmetic shift would produce references near 255.

// File: rtl/spwm3_pkg.sv
package spwm3_pkg;

    localparam int CAR_W   = 8;
    localparam int AMP_W   = 8;
    localparam int N_SMP   = 60;
    localparam int N_PH    = 3;
    localparam int PH_STEP = N_SMP / N_PH;
    localparam int QTR     = N_SMP / 4;
    localparam int PTR_W   = $clog2(N_SMP);
    localparam int DEV_W   = CAR_W + 1;
    localparam int PROD_W  = 2 * (AMP_W + 1);
    localparam int MID     = 1 << (CAR_W - 1);

    typedef logic [CAR_W-1:0] car_t;
    typedef logic [PTR_W-1:0] ptr_t;
    typedef logic [AMP_W-1:0] amp_t;
    typedef logic signed [DEV_W-1:0] dev_t;

    localparam car_t CAR_TOP = '1;
    localparam ptr_t PTR_LAST = ptr_t'(N_SMP - 1);
    localparam ptr_t Q1 = ptr_t'(QTR);
    localparam ptr_t Q2 = ptr_t'(2 * QTR);
    localparam ptr_t Q3 = ptr_t'(3 * QTR);
    localparam ptr_t Q4 = ptr_t'(N_SMP);

    typedef enum logic {DIR_UP = 1'b0, DIR_DN = 1'b1} dir_e;

    typedef struct packed {
        car_t level;
        dir_e dir;
    } carrier_s;

    // quarter-wave magnitudes, 120*sin(6 deg * k) rounded
    function automatic logic [6:0] qtr_mag(input ptr_t k);
        logic [6:0] m;
        case (k)
            6'd0:    m = 7'd0;
            6'd1:    m = 7'd13;
            6'd2:    m = 7'd25;
            6'd3:    m = 7'd37;
            6'd4:    m = 7'd49;
            6'd5:    m = 7'd60;
            6'd6:    m = 7'd71;
            6'd7:    m = 7'd80;
            6'd8:    m = 7'd89;
            6'd9:    m = 7'd97;
            6'd10:   m = 7'd104;
            6'd11:   m = 7'd110;
            6'd12:   m = 7'd114;
            6'd13:   m = 7'd117;
            6'd14:   m = 7'd119;
            default: m = 7'd120;
        endcase
        return m;
    endfunction

    // signed deviation of one full-wave entry, built from quarter symmetry
    function automatic dev_t wave_dev(input ptr_t idx);
        dev_t d;
        if (idx <= Q1)
            d = $signed({2'b00, qtr_mag(idx)});
        else if (idx < Q2)
            d = $signed({2'b00, qtr_mag(Q2 - idx)});
        else if (idx <= Q3)
            d = -$signed({2'b00, qtr_mag(idx - Q2)});
        else
            d = -$signed({2'b00, qtr_mag(Q4 - idx)});
        return d;
    endfunction

    // centre + (dev * amp) / 2^AMP_W with floor, clamped to carrier range
    function automatic car_t scale_ref(input dev_t dev, input amp_t amp);
        logic signed [PROD_W-1:0] a;
        logic signed [PROD_W-1:0] b;
        logic signed [PROD_W-1:0] lvl;
        car_t r;
        a   = PROD_W'(dev);
        b   = PROD_W'($signed({1'b0, amp}));
        lvl = ((a * b) >>> AMP_W) + PROD_W'(MID);
        if (lvl < 0)
            r = '0;
        else if (lvl > PROD_W'(CAR_TOP))
            r = CAR_TOP;
        else
            r = lvl[CAR_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/spwm3_carrier.sv
module spwm3_carrier
    import spwm3_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    output carrier_s car,
    output logic     valley
);
    carrier_s st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st.level <= '0;
            st.dir   <= DIR_UP;
        end else begin
            case (st.dir)
                DIR_UP: begin
                    if (st.level == CAR_TOP) begin
                        st.dir   <= DIR_DN;
                        st.level <= st.level - 1'b1;
                    end else begin
                        st.level <= st.level + 1'b1;
                    end
                end
                default: begin
                    if (st.level == '0) begin
                        st.dir   <= DIR_UP;
                        st.level <= st.level + 1'b1;
                    end else begin
                        st.level <= st.level - 1'b1;
                    end
                end
            endcase
        end
    end

    assign car    = st;
    assign valley = (st.level == '0) && (st.dir == DIR_DN);
endmodule

// File: rtl/spwm3_pointer.sv
module spwm3_pointer
    import spwm3_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output ptr_t ptr
);
    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (adv)
            ptr <= (ptr == PTR_LAST) ? '0 : ptr + 1'b1;
    end
endmodule

// File: rtl/spwm3_phase_ref.sv
module spwm3_phase_ref
    import spwm3_pkg::*;
#(
    parameter int OFFSET = 0
) (
    input  ptr_t ptr,
    input  amp_t amp,
    output car_t lvl
);
    localparam logic [PTR_W:0] OFF_W = (PTR_W + 1)'(OFFSET);
    localparam logic [PTR_W:0] LIM_W = (PTR_W + 1)'(N_SMP);

    logic [PTR_W:0] sum;
    ptr_t           idx;

    always_comb begin
        sum = {1'b0, ptr} + OFF_W;
        idx = (sum >= LIM_W) ? ptr_t'(sum - LIM_W) : ptr_t'(sum);
        lvl = scale_ref(wave_dev(idx), amp);
    end
endmodule

// File: rtl/spwm3_gen.sv
module spwm3_gen
    import spwm3_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] amp_i,
    output logic [7:0] carrier_o,
    output logic [2:0] pwm_o
);
    carrier_s        car_w;
    logic            valley_w;
    ptr_t            ptr_w;
    car_t            ref_w [N_PH];
    logic [N_PH-1:0] cmp_w;
    logic [N_PH-1:0] pwm_q;

    spwm3_carrier u_car (
        .clk    (clk),
        .rst    (rst),
        .car    (car_w),
        .valley (valley_w)
    );

    spwm3_pointer u_ptr (
        .clk (clk),
        .rst (rst),
        .adv (valley_w),
        .ptr (ptr_w)
    );

    for (genvar p = 0; p < N_PH; p++) begin : g_phase
        spwm3_phase_ref #(.OFFSET(p * PH_STEP)) u_ref (
            .ptr (ptr_w),
            .amp (amp_i),
            .lvl (ref_w[p])
        );
        assign cmp_w[p] = (car_w.level <= ref_w[p]);
    end

    always_ff @(posedge clk) begin
        if (rst)
            pwm_q <= '0;
        else
            pwm_q <= cmp_w;
    end

    assign carrier_o = car_w.level;
    assign pwm_o     = pwm_q;
endmodule

module spwm3_gen_chk
    import spwm3_pkg::*;
(
    input logic clk,
    input logic rst,
    input car_t carrier,
    input ptr_t ptr
);
    // R2
    peak_turn_chk: assert property (@(posedge clk) disable iff (rst)
        (carrier == CAR_TOP) |=> (carrier == CAR_TOP - 1'b1));

    // R2
    carrier_step_chk: assert property (@(posedge clk) disable iff (rst)
        (carrier != CAR_TOP && carrier != '0) |=>
        (carrier == car_t'($past(carrier) + 1'b1) || carrier == car_t'($past(carrier) - 1'b1)));

    // R2
    valley_turn_chk: assert property (@(posedge clk) disable iff (rst)
        (carrier == '0) |=> (carrier == car_t'(1)));

    // R4
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (carrier != '0) |=> $stable(ptr));

    // R4
    ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
        (ptr <= PTR_LAST));
endmodule

bind spwm3_gen spwm3_gen_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .carrier (carrier_o),
    .ptr     (ptr_w)
);

// File: tb/spwm3_gen_bench.sv
module spwm3_gen_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] amp = 8'd0;
    logic [7:0] carrier_o;
    logic [2:0] pwm_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int last_zero = -1;
    bit done = 0;

    int   m_lvl;
    bit   m_up;
    int   m_ptr;
    logic [2:0] exp_pwm;

    always #2 clk = ~clk;

    spwm3_gen u_spwm3_gen (
        .clk       (clk),
        .rst       (rst),
        .amp_i     (amp),
        .carrier_o (carrier_o),
        .pwm_o     (pwm_o)
    );

    task automatic check_val(input string req, input int act, input int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, expv);
        end
    endtask

    // R3: table deviation computed from the sine itself
    function automatic int dev_of(input int i);
        real x;
        x = 120.0 * $sin(2.0 * 3.141592653589793 * i / 60.0);
        return (x >= 0.0) ? $rtoi(x + 0.5) : $rtoi(x - 0.5);
    endfunction

    // R6: scaled reference
    function automatic int ref_of(input int i, input int a);
        int p;
        int r;
        p = dev_of(i) * a;
        r = 128 + (p >>> 8);
        if (r < 0) r = 0;
        if (r > 255) r = 255;
        return r;
    endfunction

    task automatic model_reset();
        m_lvl = 0; m_up = 1; m_ptr = 0; exp_pwm = 3'b000; last_zero = -1;
    endtask

    // one clock: predict from pre-edge state, advance model, compare after edge
    task automatic step(input int a);
        amp = 8'(a);
        for (int p = 0; p < 3; p++)
            exp_pwm[p] = (m_lvl <= ref_of((m_ptr + 20 * p) % 60, a)); // R5 R7
        if (m_up) begin
            if (m_lvl == 255) begin m_up = 0; m_lvl = 254; end
            else m_lvl++;
        end else begin
            if (m_lvl == 0) begin
                m_up = 1; m_lvl = 1;
                m_ptr = (m_ptr + 1) % 60; // R4
            end else m_lvl--;
        end
        @(negedge clk);
        cyc++;
        check_val("R2 carrier level", int'(carrier_o), m_lvl);
        check_val("R3/R4/R5/R6/R7 pwm pattern", int'(pwm_o), int'(exp_pwm));
        if (carrier_o == 8'd0) begin
            if (last_zero >= 0) check_val("R2 carrier period", cyc - last_zero, 510);
            last_zero = cyc;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check_val("R1 reset carrier", int'(carrier_o), 0);
        check_val("R1 reset pwm", int'(pwm_o), 0);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        int hi [3];
        do_reset();
        // R4: more than a full pointer cycle at near-full depth
        for (int i = 0; i < 61 * 510; i++) step(255);
        // R8: zero amplitude duty
        for (int i = 0; i < 600; i++) step(0);
        for (int p = 0; p < 3; p++) hi[p] = 0;
        for (int i = 0; i < 510; i++) begin
            step(0);
            for (int p = 0; p < 3; p++) hi[p] += int'(pwm_o[p]);
        end
        for (int p = 0; p < 3; p++) check_val("R8 zero-amplitude duty", hi[p], 257);
        // mid-run reset R1
        do_reset();
        for (int i = 0; i < 60 * 510; i++) step(100);
        // R7: amplitude changing in mid-slope
        for (int i = 0; i < 20 * 510; i++) step(((i / 37) * 53) % 256);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule